// File: doc/BRIEF.md
# Physically Tagged Cache with Overlapped Translation

This block is a direct-mapped data cache of 1024 lines, each holding one 32-bit word (4 KB in all), whose line index is taken entirely from the untranslated page-offset bits of the virtual address. The block can therefore read its arrays in the same cycle that an external translation unit turns the virtual page number into a physical frame number. Translation never alters those offset bits.

In the cycle a lookup is accepted, the block presents the 20-bit virtual page number on a translation port. It also registers the selected line's valid bit, stored frame tag and data word. In that same cycle it registers the translation outcome (hit flag and frame number). One cycle later it compares the stored tag with the translated frame number. The result is one of three outcomes:

- a hit, with the data word;
- a memory request carrying the full physical address, when translation succeeded but the cache missed;
- a translation-walk request with no memory access, when translation failed.

Lines are filled through a simple write port that takes a physical address and a data word. A stall input holds off acceptance while the translation result is not yet ready.

Top module: `ovl_cache`

## Requirements
- R1: After reset every line is invalid, and hit, mem_req and walk_req are all low until a lookup is accepted.
- R2: A lookup is accepted in a cycle where req_valid is high and xlat_stall is low. xlat_vpn always equals req_va[31:12]. The line is selected by req_va[11:2]. The outcome appears on the outputs in the cycle after acceptance.
- R3: If the selected line is valid, xlat_hit is high and the stored tag equals xlat_pfn, then hit is high and rd_data is the stored word.
- R4: If xlat_hit is high but the line is invalid or its tag differs from xlat_pfn, then mem_req is high and mem_pa equals {xlat_pfn, req_va[11:0]}.
- R5: If xlat_hit is low, then walk_req is high and both hit and mem_req are low, even when the line's tag would match.
- R6: While xlat_stall is high, no lookup is accepted, and none of the three outcome signals is high in the following cycle.
- R7: A fill (fill_en high) writes fill_data and the tag fill_pa[31:12] into line fill_pa[11:2] and marks the line valid. A later lookup that translates to that frame hits.
- R8: A fill to a line that already holds data replaces its tag and word, so the old frame now misses and the new frame hits with the new word.
- R9: A fill and a lookup on the same line in the same cycle return the line's contents from before the fill.
- R10: For each accepted lookup exactly one of hit, mem_req and walk_req is high in the next cycle. All three are low in any cycle that follows no accepted lookup.
- R11: Two virtual addresses with different page numbers and the same page offset, both translated to the same frame, hit the same line and return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address of the lookup |
| xlat_vpn | output | 20 | Virtual page number sent for translation |
| xlat_stall | input | 1 | Translation result not ready; hold off acceptance |
| xlat_hit | input | 1 | Translation succeeded |
| xlat_pfn | input | 20 | Translated physical frame number |
| fill_en | input | 1 | Refill write strobe |
| fill_pa | input | 32 | Physical address of the refill |
| fill_data | input | 32 | Refill data word |
| hit | output | 1 | Cache hit; rd_data valid |
| rd_data | output | 32 | Data word of the hit line |
| mem_req | output | 1 | Cache miss with successful translation |
| mem_pa | output | 32 | Physical address for the memory request |
| walk_req | output | 1 | Translation failed; full translation walk needed |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 4 KB page, a 10-bit index and 4-byte lines. With those values the index and offset bits fill the page offset exactly. Because of this, lookups at line 0 and line 1023 and synonym addresses that differ only above bit 11 can all be driven directly. Frame numbers of all zeros and all ones then exercise both extremes of the tag compare.

// File: rtl/ovl_cache.sv
module ovl_cache #(
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_va,
  output logic [VA_W-PAGE_W-1:0]   xlat_vpn,
  input  logic                     xlat_stall,
  input  logic                     xlat_hit,
  input  logic [VA_W-PAGE_W-1:0]   xlat_pfn,
  input  logic                     fill_en,
  input  logic [VA_W-1:0]          fill_pa,
  input  logic [(8<<OFF_W)-1:0]    fill_data,
  output logic                     hit,
  output logic [(8<<OFF_W)-1:0]    rd_data,
  output logic                     mem_req,
  output logic [VA_W-1:0]          mem_pa,
  output logic                     walk_req
);
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int DATA_W = 8 << OFF_W;
  localparam int LINES  = 1 << IDX_W;

  logic [LINES-1:0]  vld;
  logic [VPN_W-1:0]  tag_mem [LINES];
  logic [DATA_W-1:0] dat_mem [LINES];

  logic [IDX_W-1:0]  idx, fidx;
  logic              accept;

  logic              s1_v, s1_lv, s1_th;
  logic [VPN_W-1:0]  s1_tag, s1_pfn;
  logic [DATA_W-1:0] s1_data;
  logic [PAGE_W-1:0] s1_off;
  logic              tag_eq;

  assign idx      = req_va[OFF_W +: IDX_W];
  assign fidx     = fill_pa[OFF_W +: IDX_W];
  assign accept   = req_valid & ~xlat_stall;
  assign xlat_vpn = req_va[VA_W-1:PAGE_W];

  // valid bits are the only array state that needs a reset
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       vld <= '0;
    else if (fill_en) vld[fidx] <= 1'b1;

  always_ff @(posedge clk)
    if (fill_en) begin
      tag_mem[fidx] <= fill_pa[VA_W-1:PAGE_W];
      dat_mem[fidx] <= fill_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= accept;

  // array read and translation result captured at the same edge
  always_ff @(posedge clk)
    if (accept) begin
      s1_lv   <= vld[idx];
      s1_tag  <= tag_mem[idx];
      s1_data <= dat_mem[idx];
      s1_th   <= xlat_hit;
      s1_pfn  <= xlat_pfn;
      s1_off  <= req_va[PAGE_W-1:0];
    end

  assign tag_eq   = (s1_tag == s1_pfn);
  assign hit      = s1_v & s1_th & s1_lv & tag_eq;
  assign mem_req  = s1_v & s1_th & ~(s1_lv & tag_eq);
  assign walk_req = s1_v & ~s1_th;
  assign rd_data  = s1_data;
  assign mem_pa   = {s1_pfn, s1_off};

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, mem_req, walk_req})); // R10
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_stall) |=> (hit || mem_req || walk_req)); // R2
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && !xlat_stall)) |=> !(hit || mem_req || walk_req)); // R6
  AST_WALK_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_stall && !xlat_hit) |=> (walk_req && !mem_req && !hit)); // R5
  AST_MISS_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_stall && xlat_hit) |=>
      (!mem_req || mem_pa == {$past(xlat_pfn), $past(req_va[PAGE_W-1:0])})); // R4
endmodule

// File: tb/ovl_cache_bench.sv
module ovl_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [19:0] xlat_vpn;
  logic        xlat_stall = 1'b0;
  logic        xlat_hit = 1'b0;
  logic [19:0] xlat_pfn = '0;
  logic        fill_en = 1'b0;
  logic [31:0] fill_pa = '0;
  logic [31:0] fill_data = '0;
  logic        hit, mem_req, walk_req;
  logic [31:0] rd_data, mem_pa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ovl_cache u_ovl_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .xlat_vpn(xlat_vpn), .xlat_stall(xlat_stall), .xlat_hit(xlat_hit),
    .xlat_pfn(xlat_pfn), .fill_en(fill_en), .fill_pa(fill_pa),
    .fill_data(fill_data), .hit(hit), .rd_data(rd_data), .mem_req(mem_req),
    .mem_pa(mem_pa), .walk_req(walk_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic outc(input string req, input logic h, input logic m, input logic w);
    chk(req, {61'd0, hit, mem_req, walk_req}, {61'd0, h, m, w});
  endtask

  task automatic fill(input logic [31:0] pa, input logic [31:0] d);
    @(negedge clk);
    fill_en = 1'b1; fill_pa = pa; fill_data = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // drives a lookup, checks the outcome one cycle later
  task automatic look(input string req, input logic [31:0] va, input logic th,
                      input logic [19:0] pfn, input logic h, input logic m, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; xlat_hit = th; xlat_pfn = pfn;
    #1 chk("R2 vpn", {44'd0, xlat_vpn}, {44'd0, va[31:12]});
    @(negedge clk);
    req_valid = 1'b0;
    outc(req, h, m, w);
  endtask

  task automatic t_reset;
    @(negedge clk);
    outc("R1 idle after reset", 0, 0, 0);
    look("R1 cold line 0", 32'h0000_0000, 1, 20'h00000, 0, 1, 0);
    look("R1 cold line 1023", 32'h0000_0FFC, 1, 20'hFFFFF, 0, 1, 0);
    @(negedge clk);
    outc("R10 idle after lookup", 0, 0, 0);
  endtask

  task automatic t_fill_hit;
    fill({20'h12345, 12'h238}, 32'hDEAD_BEEF);
    look("R7 hit after fill", {20'hABCDE, 12'h238}, 1, 20'h12345, 1, 0, 0);
    chk("R3 data", {32'd0, rd_data}, {32'd0, 32'hDEAD_BEEF});
    fill({20'hFFFFF, 12'hFFC}, 32'h0123_4567);
    look("R3 hit line 1023", {20'h00007, 12'hFFC}, 1, 20'hFFFFF, 1, 0, 0);
    chk("R3 data 1023", {32'd0, rd_data}, {32'd0, 32'h0123_4567});
  endtask

  task automatic t_mismatch;
    look("R4 tag mismatch", {20'hABCDE, 12'h23B}, 1, 20'h12344, 0, 1, 0);
    chk("R4 mem_pa", {32'd0, mem_pa}, {32'd0, 20'h12344, 12'h23B});
  endtask

  task automatic t_walk;
    look("R5 walk even if tag matches", {20'hABCDE, 12'h238}, 0, 20'h12345, 0, 0, 1);
  endtask

  task automatic t_stall;
    @(negedge clk);
    req_valid = 1'b1; req_va = {20'h1, 12'h238}; xlat_hit = 1'b1;
    xlat_pfn = 20'h12345; xlat_stall = 1'b1;
    @(negedge clk);
    outc("R6 no response under stall", 0, 0, 0);
    @(negedge clk);
    outc("R6 still none", 0, 0, 0);
    xlat_stall = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    outc("R6 response after release", 1, 0, 0);
  endtask

  task automatic t_overwrite;
    fill({20'h55555, 12'h238}, 32'hCAFE_F00D);
    look("R8 old frame misses", {20'h3, 12'h238}, 1, 20'h12345, 0, 1, 0);
    look("R8 new frame hits", {20'h3, 12'h238}, 1, 20'h55555, 1, 0, 0);
    chk("R8 new data", {32'd0, rd_data}, {32'd0, 32'hCAFE_F00D});
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fill_en = 1'b1; fill_pa = {20'h77777, 12'h400}; fill_data = 32'h1111_2222;
    req_valid = 1'b1; req_va = {20'h9, 12'h400}; xlat_hit = 1'b1; xlat_pfn = 20'h77777;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    outc("R9 pre-fill contents", 0, 1, 0);
    look("R9 hit after fill settles", {20'h9, 12'h400}, 1, 20'h77777, 1, 0, 0);
  endtask

  task automatic t_synonym;
    fill({20'h2468A, 12'h010}, 32'h5A5A_A5A5);
    look("R11 alias A", {20'h00100, 12'h010}, 1, 20'h2468A, 1, 0, 0);
    chk("R11 data A", {32'd0, rd_data}, {32'd0, 32'h5A5A_A5A5});
    look("R11 alias B", {20'hF0F00, 12'h010}, 1, 20'h2468A, 1, 0, 0);
    chk("R11 data B", {32'd0, rd_data}, {32'd0, 32'h5A5A_A5A5});
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_fill_hit;
    t_mismatch;
    t_walk;
    t_stall;
    t_overwrite;
    t_same_cycle;
    t_synonym;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary;
    end
  end
endmodule